// File: doc/BRIEF.md
# BCD Real-Time Clock with Banked Nibble Register Map

This block keeps the time of day and a hundred-year calendar for a small processor. The processor sees it as sixteen 4-bit locations addressed by a 4-bit address. A write strobe stores data and a read strobe returns data, but only while the two chip selects are in their active pair. Every time and calendar digit is read and written as a BCD nibble. Inside, each field is held as a binary count and is split into digits at the register map.

A mode location at address 0xD selects one of four banks for addresses 0x0 to 0xC. The banks are the running time, the alarm with the hour-format and leap settings, and two blocks of scratch nibbles. The mode location also starts and stops counting and enables the alarm. A 32.768 kHz clock enable drives a binary divider. The divider produces the seconds tick and two square waves, one at 16 Hz and one at 1 Hz. Either wave can be routed to the active-low alarm pin. A rising edge on the adjust input rounds the seconds to the nearest whole minute.

Top module: `bcd_rtc`

## Requirements
- R1: A write takes effect and `rdata_oe` rises only while `cs_hi`=1 and `cs_lo_n`=0. A write made with either select inactive leaves every location unchanged.
- R2: Address 0xD is the mode location in every bank. It can be read and written. Bits 1:0 select the bank (0 time, 1 alarm, 2 and 3 scratch), bit 2 enables the alarm and bit 3 enables counting.
- R3: With counting enabled, each seconds tick adds one second. The carry passes from seconds at 59 to minutes, from minutes at 59 to hours, and from hours at 23 to day of week and date. Time-bank digits are 0x0/0x1 seconds (units/tens), 0x2/0x3 minutes, 0x4/0x5 hours, 0x6 day of week (0..6), 0x7/0x8 date, 0x9/0xA month and 0xB/0xC year.
- R4: With mode bit 3 clear, the time counters hold, while the divider keeps running.
- R5: The date wraps to 1 after day 30 in April, June, September and November, and after day 31 in the other months. In February it wraps after day 29 when the leap counter is 0 and after day 28 otherwise. December rolls into January, and year 99 rolls to 00.
- R6: The 2-bit leap counter (alarm bank, 0xB, bits 1:0) steps modulo 4 each time the year steps.
- R7: Alarm bank 0xA bit 0 selects 24-hour format (1) or 12-hour format (0). In 12-hour format, hours 0 and 12 read as 12, bit 1 of 0x5 is the PM flag and bit 0 of 0x5 is the tens digit. Writes to 0x4 and 0x5 use the same format.
- R8: On a rising edge of `adjust`, seconds below 30 are cleared, and seconds of 30 or more are cleared with a carry into the minutes. In a cycle that also has a seconds tick, the adjust result replaces the tick.
- R9: Banks 2 and 3 each hold 13 independent nibbles at 0x0 to 0xC.
- R10: A write to 0xF with bit 0 set clears the six alarm digits, and with bit 1 set clears the divider. Addresses 0xE and 0xF read as 0.
- R11: Bit 2 of the 0xF write turns the 16 Hz wave on when 0, and bit 3 turns the 1 Hz wave on when 0. `alarm_n` is low while an enabled wave is high. The 16 Hz wave is divider bit DIV_BITS-5 and the 1 Hz wave is divider bit DIV_BITS-1.
- R12: With the alarm enabled, `alarm_n` is low while the alarm minute (0x2/0x3), hour (0x4/0x5) and date (0x7/0x8) digits all equal the displayed time digits.
- R13: Unused bits read as 0 and ignore writes. Examples: seconds and minutes tens keep 3 bits, day of week keeps 3 bits, month tens keeps 1 bit and the format bit keeps 1 bit.
- R14: A processor write to a time digit in the same cycle as a seconds tick sets that field from the written digit, and the tick's change to that field is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | 32.768 kHz clock enable for the divider |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, sampled each clock |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data nibble |
| adjust | input | 1 | Seconds rounding request, acts on its rising edge |
| rdata | output | 4 | Read data nibble, 0 when not driven |
| rdata_oe | output | 1 | Read data valid, enables the external bus driver |
| alarm_n | output | 1 | Active-low alarm and pulse output |

## Verification
Two collisions are forced onto one clock edge. In the first, the bench clears the divider, counts 31 enables and then raises `adjust` together with the 32nd enable, so that the rounding and the seconds tick meet. The expected seconds are 0 with the minute unchanged, not 30. In the second, a processor write to the seconds units digit lands on the tick edge. The bench expects the written digit over the old tens, with no extra second added. Randomized start times near minute, day, month and year boundaries are run for a few seconds. They are judged digit by digit against a calendar model in the bench.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       cs_hi,
  input  logic       cs_lo_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [3:0] addr,
  input  logic [3:0] wdata,
  input  logic       adjust,
  output logic [3:0] rdata,
  output logic       rdata_oe,
  output logic       alarm_n
);
  localparam int P16 = DIV_BITS - 5;
  localparam int P1  = DIV_BITS - 1;
  localparam int RAM_WORDS = 13;
  localparam logic [3:0] A_MODE = 4'hD;
  localparam logic [3:0] A_TEST = 4'hE;
  localparam logic [3:0] A_CTRL = 4'hF;

  function automatic logic [3:0] lo_d(input logic [7:0] v);
    return 4'(v % 8'd10);
  endfunction
  function automatic logic [3:0] hi_d(input logic [7:0] v);
    return 4'(v / 8'd10);
  endfunction
  function automatic logic [7:0] put_lo(input logic [7:0] v, input logic [3:0] d);
    return (v / 8'd10) * 8'd10 + {4'h0, d};
  endfunction
  function automatic logic [7:0] put_hi(input logic [7:0] v, input logic [3:0] d);
    return {4'h0, d} * 8'd10 + v % 8'd10;
  endfunction
  function automatic logic [7:0] to24(input logic [7:0] h, input logic p);
    return (h % 8'd12) + (p ? 8'd12 : 8'd0);
  endfunction
  function automatic logic [7:0] month_len(input logic [7:0] m, input logic lp);
    case (m)
      8'd2:                     return lp ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction

  logic sel, wr_en, adj_q, adj_rise, sec_tick, step;
  logic [3:0] mode;
  logic [1:0] bank;
  logic aen, run;
  logic [DIV_BITS-1:0] div;
  logic [7:0] sec, mnt, hrs, date, mon, yr;
  logic [2:0] wday;
  logic [1:0] leap;
  logic h24, p16_off, p1_off;
  logic [3:0] al_m1, al_m10, al_h1, al_h10, al_d1, al_d10;
  logic [3:0] ram [2][RAM_WORDS];

  assign sel      = cs_hi & ~cs_lo_n;
  assign wr_en    = sel & ~wr_n;
  assign rdata_oe = sel & ~rd_n;
  assign bank     = mode[1:0];
  assign aen      = mode[2];
  assign run      = mode[3];
  assign adj_rise = adjust & ~adj_q;
  assign sec_tick = tick_32k & (&div);
  assign step     = sec_tick & run;

  logic [7:0] h12;
  logic pm;
  logic [3:0] hr_u, hr_t, mn_u, mn_t, dt_u, dt_t;
  assign pm   = hrs >= 8'd12;
  assign h12  = (hrs % 8'd12 == 8'd0) ? 8'd12 : hrs % 8'd12;
  assign hr_u = h24 ? lo_d(hrs) : lo_d(h12);
  assign hr_t = h24 ? (hi_d(hrs) & 4'h3) : {2'b00, pm, h12 >= 8'd10};
  assign mn_u = lo_d(mnt);
  assign mn_t = hi_d(mnt) & 4'h7;
  assign dt_u = lo_d(date);
  assign dt_t = hi_d(date) & 4'h3;

  logic c_min, c_hr, c_day, c_mon, c_yr;
  assign c_min = (step & (sec >= 8'd59)) | (adj_rise & (sec >= 8'd30));
  assign c_hr  = c_min & (mnt >= 8'd59);
  assign c_day = c_hr & (hrs >= 8'd23);
  assign c_mon = c_day & (date >= month_len(mon, leap == 2'd0));
  assign c_yr  = c_mon & (mon >= 8'd12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_q <= 1'b0; div <= '0; mode <= 4'h0;
      sec <= 8'd0; mnt <= 8'd0; hrs <= 8'd0; wday <= 3'd0;
      date <= 8'd1; mon <= 8'd1; yr <= 8'd0; leap <= 2'd0;
      h24 <= 1'b1; p16_off <= 1'b1; p1_off <= 1'b1;
      al_m1 <= 4'h0; al_m10 <= 4'h0; al_h1 <= 4'h0;
      al_h10 <= 4'h0; al_d1 <= 4'h0; al_d10 <= 4'h0;
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < RAM_WORDS; w++) ram[b][w] <= 4'h0;
    end else begin
      adj_q <= adjust;
      if (tick_32k) div <= div + 1'b1;
      if (adj_rise) sec <= 8'd0;
      else if (step) sec <= (sec >= 8'd59) ? 8'd0 : sec + 8'd1;
      if (c_min) mnt <= (mnt >= 8'd59) ? 8'd0 : mnt + 8'd1;
      if (c_hr)  hrs <= (hrs >= 8'd23) ? 8'd0 : hrs + 8'd1;
      if (c_day) begin
        wday <= (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
        date <= c_mon ? 8'd1 : date + 8'd1;
      end
      if (c_mon) mon <= c_yr ? 8'd1 : mon + 8'd1;
      if (c_yr) begin
        yr   <= (yr >= 8'd99) ? 8'd0 : yr + 8'd1;
        leap <= leap + 2'd1;
      end
      if (wr_en) begin
        if (addr == A_MODE) mode <= wdata;
        else if (addr == A_CTRL) begin
          if (wdata[0]) begin
            al_m1 <= 4'h0; al_m10 <= 4'h0; al_h1 <= 4'h0;
            al_h10 <= 4'h0; al_d1 <= 4'h0; al_d10 <= 4'h0;
          end
          if (wdata[1]) div <= '0;
          p16_off <= wdata[2];
          p1_off  <= wdata[3];
        end else if (addr != A_TEST) begin
          case (bank)
            2'd0: case (addr)
              4'h0: sec  <= put_lo(sec, wdata);
              4'h1: sec  <= put_hi(sec, {1'b0, wdata[2:0]});
              4'h2: mnt  <= put_lo(mnt, wdata);
              4'h3: mnt  <= put_hi(mnt, {1'b0, wdata[2:0]});
              4'h4: hrs  <= h24 ? put_lo(hrs, wdata) : to24(put_lo(h12, wdata), pm);
              4'h5: hrs  <= h24 ? put_hi(hrs, {2'b00, wdata[1:0]})
                                : to24(put_hi(h12, {3'b000, wdata[0]}), wdata[1]);
              4'h6: wday <= wdata[2:0];
              4'h7: date <= put_lo(date, wdata);
              4'h8: date <= put_hi(date, {2'b00, wdata[1:0]});
              4'h9: mon  <= put_lo(mon, wdata);
              4'hA: mon  <= put_hi(mon, {3'b000, wdata[0]});
              4'hB: yr   <= put_lo(yr, wdata);
              4'hC: yr   <= put_hi(yr, wdata);
              default: ;
            endcase
            2'd1: case (addr)
              4'h2: al_m1  <= wdata;
              4'h3: al_m10 <= {1'b0, wdata[2:0]};
              4'h4: al_h1  <= wdata;
              4'h5: al_h10 <= {2'b00, wdata[1:0]};
              4'h7: al_d1  <= wdata;
              4'h8: al_d10 <= {2'b00, wdata[1:0]};
              4'hA: h24    <= wdata[0];
              4'hB: leap   <= wdata[1:0];
              default: ;
            endcase
            default: if (addr < 4'(RAM_WORDS)) ram[bank[0]][addr] <= wdata;
          endcase
        end
      end
    end
  end

  logic [3:0] rd_val;
  always_comb begin
    rd_val = 4'h0;
    if (addr == A_MODE) rd_val = mode;
    else if (addr != A_TEST && addr != A_CTRL) begin
      case (bank)
        2'd0: case (addr)
          4'h0: rd_val = lo_d(sec);
          4'h1: rd_val = hi_d(sec) & 4'h7;
          4'h2: rd_val = mn_u;
          4'h3: rd_val = mn_t;
          4'h4: rd_val = hr_u;
          4'h5: rd_val = hr_t;
          4'h6: rd_val = {1'b0, wday};
          4'h7: rd_val = dt_u;
          4'h8: rd_val = dt_t;
          4'h9: rd_val = lo_d(mon);
          4'hA: rd_val = hi_d(mon) & 4'h1;
          4'hB: rd_val = lo_d(yr);
          4'hC: rd_val = hi_d(yr);
          default: rd_val = 4'h0;
        endcase
        2'd1: case (addr)
          4'h2: rd_val = al_m1;
          4'h3: rd_val = al_m10;
          4'h4: rd_val = al_h1;
          4'h5: rd_val = al_h10;
          4'h7: rd_val = al_d1;
          4'h8: rd_val = al_d10;
          4'hA: rd_val = {3'b000, h24};
          4'hB: rd_val = {2'b00, leap};
          default: rd_val = 4'h0;
        endcase
        default: if (addr < 4'(RAM_WORDS)) rd_val = ram[bank[0]][addr];
      endcase
    end
  end
  assign rdata = rdata_oe ? rd_val : 4'h0;

  logic match;
  assign match = (al_m1 == mn_u) && (al_m10 == mn_t) && (al_h1 == hr_u) &&
                 (al_h10 == hr_t) && (al_d1 == dt_u) && (al_d10 == dt_t);
  assign alarm_n = ~((aen & match) | (~p16_off & div[P16]) | (~p1_off & div[P1]));
endmodule

module bcd_rtc_chk #(
  parameter int DIV_BITS = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [3:0]          addr,
  input logic [3:0]          wdata,
  input logic                sec_tick,
  input logic                run,
  input logic                adj_rise,
  input logic [7:0]          sec,
  input logic [7:0]          mnt,
  input logic [7:0]          hrs,
  input logic [7:0]          yr,
  input logic [1:0]          leap,
  input logic [DIV_BITS-1:0] div,
  input logic [23:0]         al_all
);
  a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && run && !adj_rise && !wr_en && sec < 8'd59) |=> sec == $past(sec) + 8'd1);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !adj_rise && !wr_en) |=> ($stable(sec) && $stable(mnt) && $stable(hrs)));
  a_r8_adjust_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_rise && !wr_en) |=> sec == 8'd0);
  a_r10_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hF && wdata[0]) |=> al_all == 24'h0);
  a_r10_div_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hF && wdata[1]) |=> div == '0);
  a_r6_leap_with_year: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((yr != $past(yr)) == (leap != $past(leap))));
endmodule

bind bcd_rtc bcd_rtc_chk #(.DIV_BITS(DIV_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .sec_tick(sec_tick), .run(run), .adj_rise(adj_rise),
  .sec(sec), .mnt(mnt), .hrs(hrs), .yr(yr), .leap(leap), .div(div),
  .al_all({al_m1, al_m10, al_h1, al_h10, al_d1, al_d10})
);

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;
  localparam int DIVB = 5;
  localparam int SECN = 1 << DIVB;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tick_32k = 1'b0, cs_hi = 1'b1, cs_lo_n = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1, adjust = 1'b0;
  logic [3:0] addr = 4'h0, wdata = 4'h0, rdata;
  logic rdata_oe, alarm_n;

  always #5 clk = ~clk;

  bcd_rtc #(.DIV_BITS(DIVB)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata), .adjust(adjust),
    .rdata(rdata), .rdata_oe(rdata_oe), .alarm_n(alarm_n)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int t_sec, t_min, t_hr, t_wd, t_date, t_mon, t_yr, t_leap;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk); addr = a; rd_n = 1'b0;
    #1 v = int'(rdata);
    rd_n = 1'b1;
  endtask

  task automatic rd_chk(input string req, input string what, input logic [3:0] a, input int exp);
    int v;
    rd(a, v);
    check(req, what, v, exp);
  endtask

  function automatic int mlen(input int m, input int lp);
    if (m == 2) return (lp == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic adv1();
    t_sec++;
    if (t_sec == 60) begin
      t_sec = 0; t_min++;
      if (t_min == 60) begin
        t_min = 0; t_hr++;
        if (t_hr == 24) begin
          t_hr = 0; t_wd = (t_wd + 1) % 7; t_date++;
          if (t_date > mlen(t_mon, t_leap)) begin
            t_date = 1; t_mon++;
            if (t_mon == 13) begin
              t_mon = 1; t_yr = (t_yr + 1) % 100; t_leap = (t_leap + 1) % 4;
            end
          end
        end
      end
    end
  endtask

  task automatic load_time();
    wr(4'hD, 4'h1); wr(4'hA, 4'h1); wr(4'hB, 4'(t_leap));
    wr(4'hD, 4'h0);
    wr(4'h0, 4'(t_sec % 10));  wr(4'h1, 4'(t_sec / 10));
    wr(4'h2, 4'(t_min % 10));  wr(4'h3, 4'(t_min / 10));
    wr(4'h4, 4'(t_hr % 10));   wr(4'h5, 4'(t_hr / 10));
    wr(4'h6, 4'(t_wd));
    wr(4'h7, 4'(t_date % 10)); wr(4'h8, 4'(t_date / 10));
    wr(4'h9, 4'(t_mon % 10));  wr(4'hA, 4'(t_mon / 10));
    wr(4'hB, 4'(t_yr % 10));   wr(4'hC, 4'(t_yr / 10));
  endtask

  task automatic verify_time(input string req);
    rd_chk(req, "sec units", 4'h0, t_sec % 10);   rd_chk(req, "sec tens", 4'h1, t_sec / 10);
    rd_chk(req, "min units", 4'h2, t_min % 10);   rd_chk(req, "min tens", 4'h3, t_min / 10);
    rd_chk(req, "hour units", 4'h4, t_hr % 10);   rd_chk(req, "hour tens", 4'h5, t_hr / 10);
    rd_chk(req, "weekday", 4'h6, t_wd);
    rd_chk(req, "date units", 4'h7, t_date % 10); rd_chk(req, "date tens", 4'h8, t_date / 10);
    rd_chk(req, "month units", 4'h9, t_mon % 10); rd_chk(req, "month tens", 4'hA, t_mon / 10);
    rd_chk(req, "year units", 4'hB, t_yr % 10);   rd_chk(req, "year tens", 4'hC, t_yr / 10);
    wr(4'hD, 4'h1);
    rd_chk("R6", "leap counter", 4'hB, t_leap);
    wr(4'hD, 4'h0);
  endtask

  task automatic run_secs(input int n);
    wr(4'hD, 4'h8);
    wr(4'hF, 4'hE);
    tick_32k = 1'b1;
    repeat (SECN * n) @(negedge clk);
    tick_32k = 1'b0;
    wr(4'hD, 4'h0);
    for (int i = 0; i < n; i++) adv1();
  endtask

  task automatic do_case(input int s, input int mi, input int h, input int wd, input int dt,
                         input int mo, input int y, input int lp, input int n, input string req);
    t_sec = s; t_min = mi; t_hr = h; t_wd = wd; t_date = dt; t_mon = mo; t_yr = y; t_leap = lp;
    load_time();
    run_secs(n);
    verify_time(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd4817));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    check("R1", "oe idle after reset", int'(rdata_oe), 0);
    check("R11", "alarm_n after reset", int'(alarm_n), 1);
    rd_chk("R2", "mode after reset", 4'hD, 0);
    rd_chk("R3", "sec after reset", 4'h0, 0);
    rd_chk("R5", "date after reset", 4'h7, 1);
    rd_chk("R5", "month after reset", 4'h9, 1);

    // R3 R5 R6 directed boundaries
    do_case(58, 59, 23, 6, 28, 2, 24, 0, 3, "R5");
    do_case(59, 59, 23, 2, 28, 2, 23, 3, 1, "R5");
    do_case(59, 59, 23, 4, 30, 4, 10, 1, 1, "R5");
    do_case(59, 59, 23, 5, 31, 12, 99, 3, 2, "R6");
    do_case(57, 8, 9, 0, 12, 7, 41, 2, 4, "R3");

    // R3 randomized near boundaries
    for (int it = 0; it < 14; it++) begin
      int s, mi, h, mo, lp, dt;
      s  = 54 + int'($urandom % 6);
      mi = ($urandom % 2) ? 59 : int'($urandom % 60);
      h  = ($urandom % 2) ? 23 : int'($urandom % 24);
      mo = ($urandom % 3 == 0) ? 12 : 1 + int'($urandom % 12);
      lp = int'($urandom % 4);
      dt = ($urandom % 2) ? mlen(mo, lp) : 1 + int'($urandom % 28);
      do_case(s, mi, h, int'($urandom % 7), dt, mo,
              ($urandom % 3 == 0) ? 99 : int'($urandom % 100), lp,
              1 + int'($urandom % 6), "R3");
    end

    // R4 stopped counting
    t_sec = 17; t_min = 4; t_hr = 5; t_wd = 1; t_date = 9; t_mon = 3; t_yr = 7; t_leap = 1;
    load_time();
    wr(4'hF, 4'hE);
    tick_32k = 1'b1; repeat (3 * SECN) @(negedge clk); tick_32k = 1'b0;
    rd_chk("R4", "sec held", 4'h0, 7);
    rd_chk("R4", "sec tens held", 4'h1, 1);

    // R8 adjust rounding
    wr(4'h1, 4'h2); wr(4'h0, 4'h9);
    @(negedge clk); adjust = 1'b1; @(negedge clk); adjust = 1'b0;
    rd_chk("R8", "sec after adjust <30", 4'h0, 0);
    rd_chk("R8", "min after adjust <30", 4'h2, 4);
    wr(4'h1, 4'h4); wr(4'h0, 4'h1);
    @(negedge clk); adjust = 1'b1; @(negedge clk); adjust = 1'b0;
    rd_chk("R8", "sec tens after adjust >=30", 4'h1, 0);
    rd_chk("R8", "min after adjust >=30", 4'h2, 5);

    // R8 adjust and tick on the same edge
    wr(4'h1, 4'h2); wr(4'h0, 4'h9);
    wr(4'hD, 4'h8); wr(4'hF, 4'hE);
    tick_32k = 1'b1; repeat (SECN - 1) @(negedge clk);
    adjust = 1'b1; @(negedge clk);
    tick_32k = 1'b0; adjust = 1'b0;
    wr(4'hD, 4'h0);
    rd_chk("R8", "collide sec units", 4'h0, 0);
    rd_chk("R8", "collide sec tens", 4'h1, 0);
    rd_chk("R8", "collide min", 4'h2, 5);

    // R14 write on the tick edge
    wr(4'h1, 4'h2); wr(4'h0, 4'h0);
    wr(4'hD, 4'h8); wr(4'hF, 4'hE);
    tick_32k = 1'b1; repeat (SECN - 1) @(negedge clk);
    addr = 4'h0; wdata = 4'h7; wr_n = 1'b0; @(negedge clk);
    wr_n = 1'b1; tick_32k = 1'b0;
    wr(4'hD, 4'h0);
    rd_chk("R14", "written units win", 4'h0, 7);
    rd_chk("R14", "tens kept", 4'h1, 2);

    // R7 hour formats
    wr(4'h5, 4'h1); wr(4'h4, 4'h3);
    wr(4'hD, 4'h1); wr(4'hA, 4'h0); wr(4'hD, 4'h0);
    rd_chk("R7", "13h units in 12h", 4'h4, 1);
    rd_chk("R7", "13h tens+PM", 4'h5, 2);
    wr(4'hD, 4'h1); wr(4'hA, 4'h1); wr(4'hD, 4'h0);
    wr(4'h5, 4'h0); wr(4'h4, 4'h0);
    wr(4'hD, 4'h1); wr(4'hA, 4'h0); wr(4'hD, 4'h0);
    rd_chk("R7", "0h shows 12 units", 4'h4, 2);
    rd_chk("R7", "0h shows 12 AM tens", 4'h5, 1);
    wr(4'h5, 4'h2); wr(4'h4, 4'h5);
    wr(4'hD, 4'h1); wr(4'hA, 4'h1); wr(4'hD, 4'h0);
    rd_chk("R7", "12h write 5 PM units", 4'h4, 7);
    rd_chk("R7", "12h write 5 PM tens", 4'h5, 1);

    // R13 unused bits
    wr(4'h6, 4'hF);
    rd_chk("R13", "weekday 3 bits", 4'h6, 7);
    wr(4'hA, 4'hF);
    rd_chk("R13", "month tens 1 bit", 4'hA, 1);
    wr(4'hE, 4'hF);
    rd_chk("R10", "test addr reads 0", 4'hE, 0);
    rd_chk("R10", "ctrl addr reads 0", 4'hF, 0);
    wr(4'hD, 4'h1); wr(4'hA, 4'hF);
    rd_chk("R13", "format bit 1 bit", 4'hA, 1);
    wr(4'hD, 4'h0);

    // R12 alarm match
    wr(4'h2, 4'h4); wr(4'h3, 4'h3); wr(4'h5, 4'h0); wr(4'h4, 4'h7);
    wr(4'h8, 4'h1); wr(4'h7, 4'h5); wr(4'hA, 4'h0); wr(4'h9, 4'h6);
    wr(4'hD, 4'h1);
    wr(4'h2, 4'h4); wr(4'h3, 4'h3); wr(4'h4, 4'h7); wr(4'h5, 4'h0);
    wr(4'h7, 4'h5); wr(4'h8, 4'h1);
    @(negedge clk); check("R12", "alarm off while disabled", int'(alarm_n), 1);
    wr(4'hD, 4'h5);
    @(negedge clk); check("R12", "alarm on match", int'(alarm_n), 0);
    wr(4'h2, 4'h5);
    @(negedge clk); check("R12", "alarm off on minute mismatch", int'(alarm_n), 1);
    wr(4'h2, 4'h4);
    @(negedge clk); check("R12", "alarm on again", int'(alarm_n), 0);
    wr(4'hF, 4'hD);
    @(negedge clk); check("R10", "alarm off after clear", int'(alarm_n), 1);
    rd_chk("R10", "alarm minute cleared", 4'h2, 0);
    rd_chk("R10", "alarm date tens cleared", 4'h8, 0);
    wr(4'hD, 4'h0);

    // R11 pulses
    wr(4'hF, 4'hA);
    @(negedge clk); check("R11", "16Hz low phase", int'(alarm_n), 1);
    tick_32k = 1'b1; @(negedge clk); tick_32k = 1'b0;
    check("R11", "16Hz high phase", int'(alarm_n), 0);
    wr(4'hF, 4'h6);
    tick_32k = 1'b1; repeat (SECN / 2 - 1) @(negedge clk); tick_32k = 1'b0;
    check("R11", "1Hz before half", int'(alarm_n), 1);
    tick_32k = 1'b1; @(negedge clk); tick_32k = 1'b0;
    check("R11", "1Hz at half", int'(alarm_n), 0);
    wr(4'hF, 4'hE);
    @(negedge clk); check("R11", "pulses off", int'(alarm_n), 1);

    // R9 scratch banks, R2 mode readback
    wr(4'hD, 4'h2); wr(4'h3, 4'hA); wr(4'hC, 4'h9);
    wr(4'hD, 4'h3); wr(4'h3, 4'h5);
    rd_chk("R9", "bank3 word3", 4'h3, 5);
    rd_chk("R2", "mode readback bank3", 4'hD, 3);
    wr(4'hD, 4'h2);
    rd_chk("R9", "bank2 word3", 4'h3, 10);
    rd_chk("R9", "bank2 word12", 4'hC, 9);

    // R1 chip select
    @(negedge clk); cs_hi = 1'b0;
    wr(4'h3, 4'h1);
    @(negedge clk); rd_n = 1'b0; #1 check("R1", "oe with cs_hi low", int'(rdata_oe), 0);
    rd_n = 1'b1; cs_hi = 1'b1; cs_lo_n = 1'b1;
    wr(4'h3, 4'h2);
    cs_lo_n = 1'b0;
    rd_chk("R1", "deselected writes ignored", 4'h3, 10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule